// File: doc/BRIEF.md
# Pulse and Trapezoid Shape Generator

The block turns a 12-bit phase position into one 16-bit output sample per clock. A single parametric engine draws the shape. It rises linearly from a low code to a high code, holds the high code, falls linearly back, and then holds the low code until the period ends. Three fractions of the period set the shape, each counted in units of 1/4096: the rise length, the high-time length (the duty cycle) and the fall length. Square, pulse, trapezoid, triangle and sawtooth waves are all settings of this one engine.

A phase accumulator upstream supplies the phase position. A scaling stage downstream takes the sample. Shape settings are written into a shadow set at any time. The block clips and prepares them there, with edge boundaries and reciprocal step counts. The whole set moves into the working registers only when the phase position is zero, so a period is never drawn with a mix of old and new settings. The output is registered: the sample for the phase presented on one clock edge appears after that edge.

Top module: `shape_gen`

## Requirements
- R1: After reset the working set has both level codes at 0 and all lengths at 0, and `sampleOut` is 0 until a written set has been applied.
- R2: With working rise length R, high length H and fall length F, phase p in [0,R) is the rising edge, [R,R+H) outputs the high code, [R+H,R+H+F) is the falling edge, and the rest of the period outputs the low code.
- R3: On the rising edge, with the reciprocal taken as floor(2^24/R), the sample is low + floor((high-low)·p·recip / 2^24) in signed arithmetic. It therefore starts at the low code and never leaves the range spanned by the two codes.
- R4: On the falling edge, with q = p-R-H and the reciprocal taken as floor(2^24/F), the sample is high + floor((low-high)·q·recip / 2^24).
- R5: `riseIn` and `fallIn` are 13-bit counts, and values above 4096 count as 4096. `dutyIn` is a 12-bit count. The high length is clipped to 4096-R, and then the fall length is clipped to 4096-R-H, so that the shape always fits in one 4096-step period.
- R6: When `riseIn` and `fallIn` are both 0, a `dutyIn` of 0 is taken as 1, so a sharp-edged shape always holds the high code for at least one step.
- R7: Writing with `cfgWrite` only loads the shadow set. The shadow set becomes the working set on the first clock whose `phaseIn` is 0, and the sample for that phase already uses the new set. Working settings never change on any other clock.
- R8: A write on the same clock that applies a pending set stores the new values, and these stay pending until the next clock with phase 0.
- R9: A triangle is duty 0, rise 2048, fall 2048. A sawtooth is duty 0, rise 4096, fall 0. A square wave is duty 2048 with both edges 0. Each of these follows R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseIn | input | 12 | Phase position within the period, 0 to 4095 |
| cfgWrite | input | 1 | Load the shape settings below into the shadow set |
| dutyIn | input | 12 | High-time length in 1/4096 steps |
| riseIn | input | 13 | Rising-edge length in 1/4096 steps (0 to 4096) |
| fallIn | input | 13 | Falling-edge length in 1/4096 steps (0 to 4096) |
| lowIn | input | 16 | Low-level sample code |
| highIn | input | 16 | High-level sample code |
| sampleOut | output | 16 | Registered output sample |

## Verification
The bench builds the block with its default 12-bit phase and 16-bit samples. With these widths, full 4096-step periods can be swept, both code extremes (0 and 65535) can be reached, and the widest interpolation product occurs: a 65535 code difference times a rise length of 4096 times its reciprocal. Under those conditions it checks single steps, strided sweeps and random phases, shapes with falling levels (high below low), settings that overflow the period, and a write that arrives on the very clock that applies the previous set.

// File: rtl/shape_gen_pkg.sv
package shape_gen_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic apply;   // copy the shadow set into the working set this clock
  } shapeStrobe_t;

endpackage

// File: rtl/shape_gen_ctrl.sv
module shape_gen_ctrl
  import shape_gen_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int DATA_W  = 16,
  localparam int LEN_W  = PHASE_W + 1,
  localparam int REC_W  = 2 * PHASE_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic               cfgWrite,
  input  logic [PHASE_W-1:0] dutyIn,
  input  logic [LEN_W-1:0]   riseIn,
  input  logic [LEN_W-1:0]   fallIn,
  input  logic [DATA_W-1:0]  lowIn,
  input  logic [DATA_W-1:0]  highIn,
  output shapeStrobe_t       strobe,
  output logic [LEN_W-1:0]   shRiseEnd,
  output logic [LEN_W-1:0]   shHighEnd,
  output logic [LEN_W-1:0]   shFallEnd,
  output logic [REC_W-1:0]   shRecipRise,
  output logic [REC_W-1:0]   shRecipFall,
  output logic [DATA_W-1:0]  shLow,
  output logic [DATA_W-1:0]  shHigh
);

  localparam logic [LEN_W-1:0] FULL_LEN = {1'b1, {PHASE_W{1'b0}}};
  localparam logic [REC_W-1:0] UNIT_REC = {1'b1, {(2 * PHASE_W){1'b0}}};

  logic             pending;
  logic [LEN_W-1:0] riseLen, fallRaw, dutyLen, roomHigh, highLen, roomFall, fallLen;

  function automatic logic [REC_W-1:0] recipOf(input logic [LEN_W-1:0] len);
    return (len == '0) ? '0 : UNIT_REC / REC_W'(len);
  endfunction

  // Clip the requested lengths so the shape fits one period.
  always_comb begin
    riseLen  = (riseIn > FULL_LEN) ? FULL_LEN : riseIn;
    fallRaw  = (fallIn > FULL_LEN) ? FULL_LEN : fallIn;
    dutyLen  = {1'b0, dutyIn};
    if (riseIn == '0 && fallIn == '0 && dutyIn == '0) dutyLen = LEN_W'(1);
    roomHigh = FULL_LEN - riseLen;
    highLen  = (dutyLen > roomHigh) ? roomHigh : dutyLen;
    roomFall = roomHigh - highLen;
    fallLen  = (fallRaw > roomFall) ? roomFall : fallRaw;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending     <= 1'b0;
      shRiseEnd   <= '0;
      shHighEnd   <= '0;
      shFallEnd   <= '0;
      shRecipRise <= '0;
      shRecipFall <= '0;
      shLow       <= '0;
      shHigh      <= '0;
    end else begin
      if (cfgWrite) begin
        pending     <= 1'b1;
        shRiseEnd   <= riseLen;
        shHighEnd   <= riseLen + highLen;
        shFallEnd   <= riseLen + highLen + fallLen;
        shRecipRise <= recipOf(riseLen);
        shRecipFall <= recipOf(fallLen);
        shLow       <= lowIn;
        shHigh      <= highIn;
      end else if (strobe.apply) begin
        pending <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.apply = pending && (phaseIn == '0);
  end

  AST_SPAN_FITS: assert property (@(posedge clk) disable iff (!rstN)
    (shFallEnd <= FULL_LEN) && (shRiseEnd <= shHighEnd) && (shHighEnd <= shFallEnd)); // R5

  AST_NEVER_FLAT: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrite && riseIn == '0 && fallIn == '0) |-> (shHighEnd != '0)); // R6

endmodule

// File: rtl/shape_gen_dp.sv
module shape_gen_dp
  import shape_gen_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int DATA_W  = 16,
  localparam int LEN_W  = PHASE_W + 1,
  localparam int REC_W  = 2 * PHASE_W + 1,
  localparam int SHIFT  = 2 * PHASE_W,
  localparam int MUL_W  = DATA_W + LEN_W + REC_W + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] phaseIn,
  input  shapeStrobe_t       strobe,
  input  logic [LEN_W-1:0]   shRiseEnd,
  input  logic [LEN_W-1:0]   shHighEnd,
  input  logic [LEN_W-1:0]   shFallEnd,
  input  logic [REC_W-1:0]   shRecipRise,
  input  logic [REC_W-1:0]   shRecipFall,
  input  logic [DATA_W-1:0]  shLow,
  input  logic [DATA_W-1:0]  shHigh,
  output logic [DATA_W-1:0]  sampleOut
);

  logic [LEN_W-1:0]  actRiseEnd, actHighEnd, actFallEnd;
  logic [REC_W-1:0]  actRecipRise, actRecipFall;
  logic [DATA_W-1:0] actLow, actHigh;

  logic [LEN_W-1:0]  selRiseEnd, selHighEnd, selFallEnd;
  logic [REC_W-1:0]  selRecipRise, selRecipFall;
  logic [DATA_W-1:0] selLow, selHigh;

  logic [LEN_W-1:0]        pos, fallPos;
  logic signed [DATA_W:0]  levelDiff;
  logic signed [MUL_W-1:0] riseProd, fallProd, riseVal, fallVal;
  logic [DATA_W-1:0]       nextSample;

  // A set applied this clock already governs this clock's sample.
  always_comb begin
    selRiseEnd   = strobe.apply ? shRiseEnd   : actRiseEnd;
    selHighEnd   = strobe.apply ? shHighEnd   : actHighEnd;
    selFallEnd   = strobe.apply ? shFallEnd   : actFallEnd;
    selRecipRise = strobe.apply ? shRecipRise : actRecipRise;
    selRecipFall = strobe.apply ? shRecipFall : actRecipFall;
    selLow       = strobe.apply ? shLow       : actLow;
    selHigh      = strobe.apply ? shHigh      : actHigh;
  end

  // Linear edge interpolation: difference times position times reciprocal.
  always_comb begin
    pos       = {1'b0, phaseIn};
    fallPos   = pos - selHighEnd;
    levelDiff = $signed({1'b0, selHigh}) - $signed({1'b0, selLow});
    riseProd  = MUL_W'(levelDiff) * MUL_W'($signed({1'b0, pos}))
              * MUL_W'($signed({1'b0, selRecipRise}));
    fallProd  = -(MUL_W'(levelDiff)) * MUL_W'($signed({1'b0, fallPos}))
              * MUL_W'($signed({1'b0, selRecipFall}));
    riseVal   = MUL_W'($signed({1'b0, selLow}))  + (riseProd >>> SHIFT);
    fallVal   = MUL_W'($signed({1'b0, selHigh})) + (fallProd >>> SHIFT);
  end

  // Segment decode.
  always_comb begin
    if (pos < selRiseEnd)      nextSample = DATA_W'(riseVal);
    else if (pos < selHighEnd) nextSample = selHigh;
    else if (pos < selFallEnd) nextSample = DATA_W'(fallVal);
    else                       nextSample = selLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actRiseEnd   <= '0;
      actHighEnd   <= '0;
      actFallEnd   <= '0;
      actRecipRise <= '0;
      actRecipFall <= '0;
      actLow       <= '0;
      actHigh      <= '0;
      sampleOut    <= '0;
    end else begin
      actRiseEnd   <= selRiseEnd;
      actHighEnd   <= selHighEnd;
      actFallEnd   <= selFallEnd;
      actRecipRise <= selRecipRise;
      actRecipFall <= selRecipFall;
      actLow       <= selLow;
      actHigh      <= selHigh;
      sampleOut    <= nextSample;
    end
  end

  logic [DATA_W-1:0] spanLo, spanHi;
  always_comb begin
    spanLo = (actLow < actHigh) ? actLow : actHigh;
    spanHi = (actLow < actHigh) ? actHigh : actLow;
  end

  AST_SAMPLE_IN_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (sampleOut >= spanLo) && (sampleOut <= spanHi)); // R3

  AST_HOLD_BETWEEN_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    ((actLow != $past(actLow)) || (actFallEnd != $past(actFallEnd))) |-> ($past(phaseIn) == '0)); // R7

  AST_LOAD_FROM_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.apply) |-> ((actFallEnd == $past(shFallEnd)) && (actRecipRise == $past(shRecipRise)))); // R7

endmodule

// File: rtl/shape_gen.sv
module shape_gen
  import shape_gen_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int DATA_W  = 16,
  localparam int LEN_W  = PHASE_W + 1,
  localparam int REC_W  = 2 * PHASE_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic               cfgWrite,
  input  logic [PHASE_W-1:0] dutyIn,
  input  logic [LEN_W-1:0]   riseIn,
  input  logic [LEN_W-1:0]   fallIn,
  input  logic [DATA_W-1:0]  lowIn,
  input  logic [DATA_W-1:0]  highIn,
  output logic [DATA_W-1:0]  sampleOut
);

  shapeStrobe_t      strobe;
  logic [LEN_W-1:0]  shRiseEnd, shHighEnd, shFallEnd;
  logic [REC_W-1:0]  shRecipRise, shRecipFall;
  logic [DATA_W-1:0] shLow, shHigh;

  shape_gen_ctrl #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .cfgWrite(cfgWrite),
    .dutyIn(dutyIn), .riseIn(riseIn), .fallIn(fallIn),
    .lowIn(lowIn), .highIn(highIn), .strobe(strobe),
    .shRiseEnd(shRiseEnd), .shHighEnd(shHighEnd), .shFallEnd(shFallEnd),
    .shRecipRise(shRecipRise), .shRecipFall(shRecipFall),
    .shLow(shLow), .shHigh(shHigh)
  );

  shape_gen_dp #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .strobe(strobe),
    .shRiseEnd(shRiseEnd), .shHighEnd(shHighEnd), .shFallEnd(shFallEnd),
    .shRecipRise(shRecipRise), .shRecipFall(shRecipFall),
    .shLow(shLow), .shHigh(shHigh), .sampleOut(sampleOut)
  );

endmodule

// File: tb/shape_gen_bench.sv
module shape_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 4096;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] phaseIn;
  logic        cfgWrite;
  logic [11:0] dutyIn;
  logic [12:0] riseIn, fallIn;
  logic [15:0] lowIn, highIn;
  logic [15:0] sampleOut;

  int checks = 0;
  int errors = 0;

  // reference model state: shadow (s*) and working (a*) sets
  int     sRe, sHe, sFe, sLo, sHi; longint sRr, sRf; bit pend;
  int     aRe, aHe, aFe, aLo, aHi; longint aRr, aRf;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shape_gen u_shape_gen (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .cfgWrite(cfgWrite),
    .dutyIn(dutyIn), .riseIn(riseIn), .fallIn(fallIn),
    .lowIn(lowIn), .highIn(highIn), .sampleOut(sampleOut)
  );

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected 0 cycles left", 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic longint recipOf(int len);
    return (len == 0) ? 0 : (longint'(1) << 24) / len;
  endfunction

  // Expected sample from requirements R2 to R4.
  function automatic int expect_at(int ph);
    longint num;
    if (ph < aRe) begin
      num = longint'(aHi - aLo) * ph * aRr;
      return aLo + int'(num >>> 24);
    end else if (ph < aHe) begin
      return aHi;
    end else if (ph < aFe) begin
      num = longint'(aLo - aHi) * (ph - aHe) * aRf;
      return aHi + int'(num >>> 24);
    end
    return aLo;
  endfunction

  // Shadow preparation from R5 and R6.
  task automatic model_write();
    int r, f, d, h;
    r = (int'(riseIn) > PERIOD) ? PERIOD : int'(riseIn);
    f = (int'(fallIn) > PERIOD) ? PERIOD : int'(fallIn);
    d = int'(dutyIn);
    if (riseIn == 0 && fallIn == 0 && dutyIn == 0) d = 1;
    h = (d > PERIOD - r) ? PERIOD - r : d;
    if (f > PERIOD - r - h) f = PERIOD - r - h;
    sRe = r; sHe = r + h; sFe = r + h + f;
    sRr = recipOf(r); sRf = recipOf(f);
    sLo = int'(lowIn); sHi = int'(highIn);
    pend = 1'b1;
  endtask

  task automatic check(int actual, int expected, string tag);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // Drive one phase, advance one clock, compare with the model.
  task automatic tick(int ph, bit wr, string tag);
    int exp;
    bit apply;
    phaseIn  = 12'(ph);
    cfgWrite = wr;
    apply = pend && (ph == 0);
    if (apply) begin
      aRe = sRe; aHe = sHe; aFe = sFe; aRr = sRr; aRf = sRf; aLo = sLo; aHi = sHi;
    end
    exp = expect_at(ph);
    if (wr) model_write();
    else if (apply) pend = 1'b0;
    @(negedge clk);
    check(int'(sampleOut), exp, tag);
    cfgWrite = 1'b0;
  endtask

  task automatic set_cfg(int d, int r, int f, int lo, int hi);
    dutyIn = 12'(d); riseIn = 13'(r); fallIn = 13'(f);
    lowIn = 16'(lo); highIn = 16'(hi);
  endtask

  task automatic run_from(int start, int step, string tag);
    for (int p = start; p < PERIOD; p += step) tick(p, 1'b0, tag);
  endtask

  task automatic run_random(int n, string tag);
    for (int i = 0; i < n; i++) tick(int'($urandom_range(PERIOD - 1, 1)), 1'b0, tag);
  endtask

  initial begin
    rstN = 1'b0; phaseIn = '0; cfgWrite = 1'b0;
    set_cfg(0, 0, 0, 0, 0);
    pend = 1'b0;
    sRe = 0; sHe = 0; sFe = 0; sLo = 0; sHi = 0; sRr = 0; sRf = 0;
    aRe = 0; aHe = 0; aFe = 0; aLo = 0; aHi = 0; aRr = 0; aRf = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(int'(sampleOut), 0, "R1 reset");
    run_from(0, 1, "R1");

    // triangle: written mid-period, must wait for the wrap (R7)
    set_cfg(0, 2048, 2048, 1000, 5096);
    tick(100, 1'b1, "R7");
    run_random(50, "R7");
    check(int'(sampleOut), 0, "R7 held");
    run_from(0, 1, "R9 triangle");
    tick(1024, 1'b0, "R3"); check(int'(sampleOut), 3048, "R3 rise mid");
    tick(2048, 1'b0, "R2"); check(int'(sampleOut), 5096, "R2 peak");
    tick(3072, 1'b0, "R4"); check(int'(sampleOut), 3048, "R4 fall mid");

    // sawtooth over the full code range
    set_cfg(0, 4096, 0, 0, 65535);
    tick(7, 1'b1, "R9");
    tick(0, 1'b0, "R9"); check(int'(sampleOut), 0, "R9 saw start");
    tick(4095, 1'b0, "R9"); check(int'(sampleOut), 65519, "R9 saw end");
    run_random(200, "R3");

    // square wave
    set_cfg(2048, 0, 0, 200, 40000);
    tick(9, 1'b1, "R2");
    run_from(0, 3, "R2");
    tick(2047, 1'b0, "R9"); check(int'(sampleOut), 40000, "R9 square high");
    tick(2048, 1'b0, "R9"); check(int'(sampleOut), 200, "R9 square low");

    // sharp edges with zero duty: one high step
    set_cfg(0, 0, 0, 200, 40000);
    tick(9, 1'b1, "R6");
    tick(0, 1'b0, "R6"); check(int'(sampleOut), 40000, "R6 min high");
    tick(1, 1'b0, "R6"); check(int'(sampleOut), 200, "R6 then low");
    run_random(100, "R6");

    // clipping of high and fall lengths
    set_cfg(2000, 3000, 500, 100, 9000);
    tick(9, 1'b1, "R5");
    run_from(0, 1, "R5");
    tick(4095, 1'b0, "R5"); check(int'(sampleOut), 9000, "R5 fall clipped");
    set_cfg(10, 5000, 0, 300, 700);
    tick(9, 1'b1, "R5");
    tick(0, 1'b0, "R5");
    tick(2048, 1'b0, "R5"); check(int'(sampleOut), 500, "R5 rise clamp");

    // falling levels, trapezoid
    set_cfg(500, 100, 300, 60000, 10);
    tick(9, 1'b1, "R4");
    run_from(0, 1, "R4");
    run_random(300, "R3");

    // write coinciding with the applying clock
    set_cfg(1000, 200, 200, 0, 30000);
    tick(50, 1'b1, "R8");
    set_cfg(3000, 0, 0, 5000, 6000);
    tick(0, 1'b1, "R8"); check(int'(sampleOut), 0, "R8 first set");
    run_from(1, 1, "R8");
    tick(0, 1'b0, "R8"); check(int'(sampleOut), 6000, "R8 second set");
    run_random(100, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule